// File: doc/BRIEF.md
# Self-Correcting Six-State Counter

This block is a three-bit clocked counter that cycles through six chosen codes in a fixed order that is not binary. On each enabled clock it moves along the loop 000, 001, 110, 010, 101, 100 and then back to 000. The two codes outside the loop, 011 and 111, are never reached in normal operation. They still have a defined successor, 000, so an upset flip-flop cannot leave the counter stuck outside its loop.

A test-only load port writes any three-bit value into the state register. This lets a test put the counter into an illegal code on purpose and watch it recover. Reset is synchronous and active low, and it returns the counter to 000.

Top module: `sixcnt_top`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, `count` becomes 000 after that edge. This holds whatever `en`, `tst_load` and `tst_val` are doing at the time.
- R2: With `en` high and `tst_load` low, each rising edge moves `count` one step along the loop 000 → 001 → 110 → 010 → 101 → 100.
- R3: From 100, an enabled edge returns `count` to 000, so the loop repeats with a period of six enabled clocks.
- R4: With `en` low and `tst_load` low, `count` keeps its value across an edge. This includes the illegal codes 011 and 111.
- R5: From code 011, the next enabled edge gives 000.
- R6: From code 111, the next enabled edge gives 000.
- R7: When `tst_load` is high and `rst_n` is high, the edge writes `tst_val` into `count`. This happens whether `en` is high or low.
- R8: Starting from any of the eight three-bit codes, `count` reaches 000 within at most six enabled edges, with no reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low; loads 000 |
| en | input | 1 | Advance the count on this edge when high |
| tst_load | input | 1 | Test-only: write `tst_val` into the state on this edge |
| tst_val | input | 3 | Test-only value to write into the state |
| count | output | 3 | Current state code |

## Verification
The hardest condition to create from the ports is an illegal code. Under reset and enable alone, the counter never leaves its six-code loop, so neither 011 nor 111 can be reached that way. The stimulus uses the test-only load port to write every one of the eight codes in turn. For each code it then checks two things: that the code is held while `en` is low, and how many enabled clocks it takes to return to 000. This covers the two recovery paths as well as every legal step.

// File: rtl/sixcnt_pkg.sv
// Shared width, state type and named codes for the six-state counter.
// Assumes a three-bit state; the loop order is fixed and not configurable.
package sixcnt_pkg;
    localparam int CODE_W   = 3;
    localparam int LOOP_LEN = 6;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t C_S0 = 3'b000;
    localparam code_t C_S1 = 3'b001;
    localparam code_t C_S2 = 3'b110;
    localparam code_t C_S3 = 3'b010;
    localparam code_t C_S4 = 3'b101;
    localparam code_t C_S5 = 3'b100;
    localparam code_t C_BAD_A = 3'b011;
    localparam code_t C_BAD_B = 3'b111;

    // Returns 1 when the code is one of the six loop members.
    function automatic logic is_legal(input code_t c);
        return !(c == C_BAD_A || c == C_BAD_B);
    endfunction
endpackage

// File: rtl/sixcnt_next.sv
// Next-state logic for the six-state counter.
// Pure combinational: gives the loop successor of every one of the
// eight codes. The illegal codes map explicitly to the loop start,
// and no entry is left open to the synthesis tool.
module sixcnt_next
    import sixcnt_pkg::*;
(
    input  code_t cur,
    output code_t nxt
);
    // Full successor table over all 2^CODE_W codes.
    always_comb begin
        unique case (cur)
            C_S0:    nxt = C_S1;
            C_S1:    nxt = C_S2;
            C_S2:    nxt = C_S3;
            C_S3:    nxt = C_S4;
            C_S4:    nxt = C_S5;
            C_S5:    nxt = C_S0;
            C_BAD_A: nxt = C_S0;
            C_BAD_B: nxt = C_S0;
            default: nxt = C_S0;
        endcase
    end
endmodule

// File: rtl/sixcnt_reg.sv
// State register for the six-state counter.
// On each edge the priority is: synchronous active-low reset to the
// loop start, then the test load, then the step, and otherwise hold.
// Assumes that `nxt` comes from the successor logic.
module sixcnt_reg
    import sixcnt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  logic  load,
    input  code_t load_val,
    input  code_t nxt,
    output code_t q
);
    // Update the state with the priority given in the header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= C_S0;
        end else if (load) begin
            q <= load_val;
        end else if (step) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/sixcnt_top.sv
// Self-correcting six-state counter, top level.
// Steps 000,001,110,010,101,100 on enabled clocks. Codes 011 and 111
// return to 000 on the next enabled clock. The tst_load/tst_val pair is
// for test only: it writes any state so that recovery can be exercised.
// Reset is synchronous and active low.
module sixcnt_top
    import sixcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tst_load,
    input  logic [CODE_W-1:0] tst_val,
    output logic [CODE_W-1:0] count
);
    code_t state_q;
    code_t state_d;

    sixcnt_next u_next (
        .cur (state_q),
        .nxt (state_d)
    );

    sixcnt_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (en),
        .load     (tst_load),
        .load_val (tst_val),
        .nxt      (state_d),
        .q        (state_q)
    );

    // Drive the output straight from the state flops.
    assign count = state_q;
endmodule

// File: rtl/sixcnt_top_chk.sv
// Assertion checker for sixcnt_top, attached with bind below.
// It observes the ports only and relates them across clock edges.
module sixcnt_top_chk
    import sixcnt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              tst_load,
    input logic [CODE_W-1:0] tst_val,
    input logic [CODE_W-1:0] count
);
    // R1: a sampled-low reset gives the loop start after the edge.
    assert_reset_home_R1: assert property (@(posedge clk)
        !rst_n |=> count == C_S0);

    // R2: one legal step of the loop.
    assert_step_s1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tst_load && count == C_S1) |=> count == C_S2);

    // R2: another legal step of the loop.
    assert_step_s3_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tst_load && count == C_S3) |=> count == C_S4);

    // R3: wrap from the last loop code back to the start.
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tst_load && count == C_S5) |=> count == C_S0);

    // R4: no enable and no load means hold.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !tst_load) |=> $stable(count));

    // R5: recovery from 011.
    assert_recover_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tst_load && count == C_BAD_A) |=> count == C_S0);

    // R6: recovery from 111.
    assert_recover_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tst_load && count == C_BAD_B) |=> count == C_S0);

    // R7: the test load writes the given value.
    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tst_load |=> count == $past(tst_val));

    // R8: an enabled edge never leaves the counter illegal.
    assert_no_stuck_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tst_load) |=> is_legal(count));
endmodule

bind sixcnt_top sixcnt_top_chk u_chk (.*);

// File: tb/tb_sixcnt_top.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every code through hold, step and recovery.
module tb_sixcnt_top;
    localparam int W        = 3;
    localparam int NCODES   = 1 << W;
    localparam int LOOP     = 6;
    localparam int WD_LIMIT = 5000;
    // Loop order, slot 0 in the low bits.
    localparam logic [3*LOOP-1:0] ORDER =
        {3'b100, 3'b101, 3'b010, 3'b110, 3'b001, 3'b000};

    logic         clk = 1'b0;
    logic         rst_n;
    logic         en;
    logic         tst_load;
    logic [W-1:0] tst_val;
    logic [W-1:0] count;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    sixcnt_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tst_load (tst_load),
        .tst_val  (tst_val),
        .count    (count)
    );

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    // Expected successor: find the loop slot, step one, or go to 000.
    function automatic logic [W-1:0] model_next(input logic [W-1:0] c);
        for (int i = 0; i < LOOP; i++) begin
            if (ORDER[3*i +: 3] == c) return ORDER[3*((i + 1) % LOOP) +: 3];
        end
        return 3'b000;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: count=%b expected=%b", req, act, exp);
        end
    endtask

    // One edge; inputs change and outputs are sampled 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > WD_LIMIT) begin
            n_fail++;
            $display("FAIL R8 watchdog: cycles=%0d expected below %0d",
                     cycles, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] expv;
        rst_n = 1'b0; en = 1'b1; tst_load = 1'b0; tst_val = '0;
        tick();
        check("R1 reset", count, 3'b000);
        tick();
        check("R1 reset held", count, 3'b000);
        rst_n = 1'b1;

        // R2/R3: two full loops under enable.
        expv = 3'b000;
        for (int k = 0; k < 2 * LOOP; k++) begin
            tick();
            expv = model_next(expv);
            check((expv == 3'b000) ? "R3 wrap" : "R2 step", count, expv);
        end

        // R4 hold on every legal code.
        for (int k = 0; k < LOOP; k++) begin
            en = 1'b0;
            expv = count;
            for (int h = 0; h < 3; h++) begin
                tick();
                check("R4 hold", count, expv);
            end
            en = 1'b1;
            tick();
        end

        // Sweep over all codes: load, hold, step, recover.
        for (int v = 0; v < NCODES; v++) begin
            int steps;
            en = (v % 2) == 0;
            tst_load = 1'b1;
            tst_val = W'(v);
            tick();
            check("R7 load", count, W'(v));
            tst_load = 1'b0;
            en = 1'b0;
            tick();
            check("R4 hold after load", count, W'(v));
            en = 1'b1;
            tick();
            expv = model_next(W'(v));
            if (v == 3)      check("R5 from 011", count, 3'b000);
            else if (v == 7) check("R6 from 111", count, 3'b000);
            else             check("R2 step after load", count, expv);
            steps = 1;
            while (count != 3'b000 && steps < 10) begin
                tick();
                steps++;
            end
            n_checks++;
            if (steps > LOOP) begin
                n_fail++;
                $display("FAIL R8 recovery from %b: steps=%0d expected <= %0d",
                         W'(v), steps, LOOP);
            end
        end

        // R7: load wins over enable; R1: reset wins over load.
        en = 1'b1; tst_load = 1'b1; tst_val = 3'b111;
        tick();
        check("R7 load over enable", count, 3'b111);
        rst_n = 1'b0; tst_val = 3'b101;
        tick();
        check("R1 reset over load", count, 3'b000);
        rst_n = 1'b1; tst_load = 1'b0; en = 1'b1;
        tick();
        check("R2 step after reset", count, 3'b001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end
endmodule